// File: doc/BRIEF.md
# Second-Order Resonant Bandpass Filter

This block is a streaming two-pole recursive filter. Each time the front end strobes in a new signed 16-bit sample, the block computes one output sample and sends it toward a converter with a one-cycle valid pulse. The numerator is a single gain term and its zero lies at z = 0, so the recursion needs only the current input and the two previous outputs. Those two past values are kept in 24-bit registers, which hold 8 more fractional bits than the sample format.

The centre frequency comes from a set of eight coefficient triples, chosen by a 3-bit index. Two single-cycle pulse inputs step the index up or down. A new triple is applied only from the next sample onward, so a step never acts in the middle of a sample's computation. Converter serial links, sample-rate generation and button debouncing belong to the surrounding design.

Top module: `iir_resonator`

## Requirements
- R1: A synchronous active-high reset clears both state registers and the band index to 0, and drives `out_smp` to 0 and `out_valid` low. After a reset, the first sample x produces output round(x·128/256).
- R2: For each accepted sample x, with states s1 (previous) and s2 (older), the new state is sat24( (G·(x·256))>>>14 + (B1·s1)>>>14 + (B2·s2)>>>14 ). Here >>> is an arithmetic right shift, so each product is floored. Afterwards s2 takes the old s1, and s1 takes the new state.
- R3: The new state saturates to the range [-2^23, 2^23-1] and never wraps.
- R4: The output sample is (state + 128) >>> 8, saturated to [-32768, 32767]. This means the positive state limit produces 32767.
- R5: `out_valid` pulses high for one cycle exactly two clock cycles after the cycle in which `in_valid` is sampled high. Input strobes must be at least two cycles apart.
- R6: A `step_up` pulse alone raises the index by 1, stopping at 7. A `step_dn` pulse alone lowers it by 1, stopping at 0. Both pulses together, or neither, leave it unchanged. The index is readable on `band_idx` one cycle after the pulse.
- R7: Coefficients are signed Q2.14: G = 8192 (0.5), B2 = -14336 (-0.875), and B1 = 24576 - 4096·k (1.5 down to -0.25) for index k.
- R8: A sample uses the index held before the clock edge that samples its `in_valid`. A step that arrives on that same edge applies only from the next sample.
- R9: Between output pulses, `out_smp` holds the last output value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_smp | input | 16 | Signed input sample |
| step_up | input | 1 | Raise band index pulse |
| step_dn | input | 1 | Lower band index pulse |
| out_smp | output | 16 | Signed output sample |
| out_valid | output | 1 | Output sample strobe |
| band_idx | output | 3 | Current coefficient-set index |

## Verification
The hardest situation to reach is state saturation. A single impulse decays long before it comes near the 24-bit limit. The stimulus therefore selects index 0, where the DC gain is 4/3, and feeds a long run of full-scale positive samples followed by a run of full-scale negative samples. The resonance overshoot then pushes the state into both rails and also exercises the rounded-output clamp. A step pulse is also placed in the same cycle as a sample strobe, to show that the step lands only on the following sample.

// File: rtl/iir_pkg.sv
package iir_pkg;

    localparam int SMP_W    = 16;
    localparam int ST_W     = 24;
    localparam int CF_W     = 16;
    localparam int CF_FRAC  = 14;
    localparam int NSETS    = 8;
    localparam int IDX_W    = $clog2(NSETS);
    localparam int EXT      = ST_W - SMP_W;
    localparam int PROD_W   = ST_W + CF_W;
    localparam int TERM_W   = PROD_W - CF_FRAC;
    localparam int SUM_W    = TERM_W + 2;
    localparam int RND_W    = ST_W + 1;
    localparam int SHR_W    = RND_W;

    localparam int GAIN_Q   = 8192;
    localparam int FB2_Q    = -14336;
    localparam int FB1_BASE = 24576;
    localparam int FB1_STEP = 4096;

    typedef logic signed [SMP_W-1:0]  smp_t;
    typedef logic signed [ST_W-1:0]   st_t;
    typedef logic signed [CF_W-1:0]   cf_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [TERM_W-1:0] term_t;
    typedef logic signed [SUM_W-1:0]  sum_t;
    typedef logic [IDX_W-1:0]         idx_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_RAISE = 2'd1,
        STEP_LOWER = 2'd2
    } step_e;

    typedef struct packed {
        cf_t gain;
        cf_t fb1;
        cf_t fb2;
    } coef_set_t;

    typedef struct packed {
        term_t t_in;
        term_t t_fb1;
        term_t t_fb2;
    } terms_t;

    function automatic coef_set_t coef_lookup(idx_t k);
        coef_set_t c;
        c.gain = cf_t'(GAIN_Q);
        c.fb2  = cf_t'(FB2_Q);
        c.fb1  = cf_t'(FB1_BASE - FB1_STEP * int'(k));
        return c;
    endfunction

    function automatic step_e decode_step(logic up, logic dn);
        if (up && !dn)
            return STEP_RAISE;
        else if (dn && !up)
            return STEP_LOWER;
        else
            return STEP_HOLD;
    endfunction

    function automatic term_t scaled_product(st_t a, cf_t c);
        prod_t p;
        p = prod_t'(a) * prod_t'(c);
        return term_t'(p >>> CF_FRAC);
    endfunction

    function automatic st_t sat_state(sum_t v);
        logic [SUM_W-ST_W:0] top;
        top = v[SUM_W-1:ST_W-1];
        if ((top == '0) || (top == '1))
            return v[ST_W-1:0];
        else if (v[SUM_W-1])
            return {1'b1, {(ST_W-1){1'b0}}};
        else
            return {1'b0, {(ST_W-1){1'b1}}};
    endfunction

    function automatic smp_t round_out(st_t s);
        logic signed [RND_W-1:0] r;
        logic signed [SHR_W-1:0] q;
        logic [SHR_W-SMP_W:0]    top;
        r   = RND_W'(s) + RND_W'(1 <<< (EXT - 1));
        q   = r >>> EXT;
        top = q[SHR_W-1:SMP_W-1];
        if ((top == '0) || (top == '1))
            return q[SMP_W-1:0];
        else if (q[SHR_W-1])
            return {1'b1, {(SMP_W-1){1'b0}}};
        else
            return {1'b0, {(SMP_W-1){1'b1}}};
    endfunction

endpackage

// File: rtl/iir_band_sel.sv
module iir_band_sel
    import iir_pkg::*;
#(
    parameter int SETS = NSETS
) (
    input  logic clk,
    input  logic rst,
    input  logic step_up,
    input  logic step_dn,
    output idx_t idx
);
    localparam idx_t TOP = idx_t'(SETS - 1);

    step_e step;
    idx_t  idx_q;

    always_comb step = decode_step(step_up, step_dn);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else begin
            unique case (step)
                STEP_RAISE: if (idx_q != TOP) idx_q <= idx_q + idx_t'(1);
                STEP_LOWER: if (idx_q != '0)  idx_q <= idx_q - idx_t'(1);
                default:    idx_q <= idx_q;
            endcase
        end
    end

    assign idx = idx_q;
endmodule

// File: rtl/iir_term_stage.sv
module iir_term_stage
    import iir_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  smp_t      x,
    input  st_t       s1,
    input  st_t       s2,
    input  coef_set_t coef,
    output terms_t    terms,
    output logic      t_valid
);
    st_t    x_ext;
    terms_t nxt;

    always_comb begin
        x_ext     = st_t'({x, {EXT{1'b0}}});
        nxt.t_in  = scaled_product(x_ext, coef.gain);
        nxt.t_fb1 = scaled_product(s1, coef.fb1);
        nxt.t_fb2 = scaled_product(s2, coef.fb2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            terms   <= '0;
            t_valid <= 1'b0;
        end else begin
            t_valid <= in_valid;
            if (in_valid) terms <= nxt;
        end
    end
endmodule

// File: rtl/iir_state_update.sv
module iir_state_update
    import iir_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   t_valid,
    input  terms_t terms,
    output st_t    s1,
    output st_t    s2,
    output smp_t   y,
    output logic   y_valid
);
    sum_t total;
    st_t  nxt_state;

    always_comb begin
        total = sum_t'(terms.t_in) + sum_t'(terms.t_fb1) + sum_t'(terms.t_fb2);
        nxt_state = sat_state(total);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1      <= '0;
            s2      <= '0;
            y       <= '0;
            y_valid <= 1'b0;
        end else begin
            y_valid <= t_valid;
            if (t_valid) begin
                s2 <= s1;
                s1 <= nxt_state;
                y  <= round_out(nxt_state);
            end
        end
    end
endmodule

// File: rtl/iir_resonator.sv
module iir_resonator
    import iir_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic signed [15:0]    in_smp,
    input  logic                  step_up,
    input  logic                  step_dn,
    output logic signed [15:0]    out_smp,
    output logic                  out_valid,
    output logic [2:0]            band_idx
);
    idx_t      idx;
    coef_set_t coef;
    terms_t    terms;
    logic      t_valid;
    st_t       s1;
    st_t       s2;
    smp_t      y;
    logic      y_valid;

    iir_band_sel #(.SETS(NSETS)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .step_up (step_up),
        .step_dn (step_dn),
        .idx     (idx)
    );

    always_comb coef = coef_lookup(idx);

    iir_term_stage u_terms (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .x        (in_smp),
        .s1       (s1),
        .s2       (s2),
        .coef     (coef),
        .terms    (terms),
        .t_valid  (t_valid)
    );

    iir_state_update u_upd (
        .clk     (clk),
        .rst     (rst),
        .t_valid (t_valid),
        .terms   (terms),
        .s1      (s1),
        .s2      (s2),
        .y       (y),
        .y_valid (y_valid)
    );

    assign out_smp   = y;
    assign out_valid = y_valid;
    assign band_idx  = idx;
endmodule

// File: rtl/iir_checker.sv
module iir_checker (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              step_up,
    input logic              step_dn,
    input logic signed [15:0] out_smp,
    input logic              out_valid,
    input logic [2:0]        band_idx
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_smp == 16'sd0 && band_idx == 3'd0));

    p_valid_after_two_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid);

    p_valid_has_cause_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));

    p_strobe_gap_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> !in_valid);

    p_idx_raise_r6: assert property (@(posedge clk) disable iff (rst)
        (step_up && !step_dn && band_idx != 3'd7) |=> band_idx == $past(band_idx) + 3'd1);

    p_idx_top_r6: assert property (@(posedge clk) disable iff (rst)
        (step_up && !step_dn && band_idx == 3'd7) |=> band_idx == 3'd7);

    p_idx_lower_r6: assert property (@(posedge clk) disable iff (rst)
        (step_dn && !step_up && band_idx != 3'd0) |=> band_idx == $past(band_idx) - 3'd1);

    p_idx_still_r6: assert property (@(posedge clk) disable iff (rst)
        !(step_up ^ step_dn) |=> $stable(band_idx));

    p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_smp));
endmodule

bind iir_resonator iir_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .out_smp   (out_smp),
    .out_valid (out_valid),
    .band_idx  (band_idx)
);

// File: tb/sim_iir_resonator.sv
module sim_iir_resonator;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_smp = '0;
    logic               step_up = 1'b0;
    logic               step_dn = 1'b0;
    logic signed [15:0] out_smp;
    logic               out_valid;
    logic [2:0]         band_idx;

    iir_resonator u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_smp    (in_smp),
        .step_up   (step_up),
        .step_dn   (step_dn),
        .out_smp   (out_smp),
        .out_valid (out_valid),
        .band_idx  (band_idx)
    );

    always #4 clk = ~clk;

    typedef struct {
        longint due;
        longint val;
    } exp_t;

    exp_t   sb[$];
    longint cyc = 0;
    int     n_chk = 0;
    int     n_err = 0;
    bit     done = 1'b0;
    longint m_s1 = 0, m_s2 = 0;
    int     m_idx = 0;
    bit     hit_pos = 1'b0, hit_neg = 1'b0;
    logic signed [15:0] prev_out = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint fl14(longint v);
        return v >>> 14;
    endfunction

    // Model from R2, R3, R4, R7
    function automatic longint model_step(longint x, int k);
        longint b1, s, r, q;
        b1 = 24576 - 4096 * k;
        s  = fl14(8192 * (x * 256)) + fl14(b1 * m_s1) + fl14(-14336 * m_s2);
        if (s > 8388607)  begin s = 8388607;  hit_pos = 1'b1; end
        if (s < -8388608) begin s = -8388608; hit_neg = 1'b1; end
        m_s2 = m_s1;
        m_s1 = s;
        r = s + 128;
        q = r >>> 8;
        if (q > 32767)  q = 32767;
        if (q < -32768) q = -32768;
        return q;
    endfunction

    task automatic send(longint x, bit up = 1'b0, bit dn = 1'b0);
        exp_t e;
        @(negedge clk);
        e.due = cyc + 2;
        e.val = model_step(x, m_idx);   // R8: index before this edge
        sb.push_back(e);
        in_valid = 1'b1;
        in_smp   = 16'(x);
        step_up  = up;
        step_dn  = dn;
        @(negedge clk);
        in_valid = 1'b0;
        step_up  = 1'b0;
        step_dn  = 1'b0;
        if (up && !dn && m_idx < 7) m_idx++;
        if (dn && !up && m_idx > 0) m_idx--;
        repeat (2) @(negedge clk);
    endtask

    task automatic step(bit up, bit dn);
        @(negedge clk);
        step_up = up;
        step_dn = dn;
        @(negedge clk);
        step_up = 1'b0;
        step_dn = 1'b0;
        if (up && !dn && m_idx < 7) m_idx++;
        if (dn && !up && m_idx > 0) m_idx--;
        chk(band_idx == 3'(m_idx), "R6 index step", band_idx, m_idx);
    endtask

    // Monitor: scoreboard pop, latency (R5), hold (R9)
    always @(negedge clk) begin
        if (rst) begin
            prev_out <= '0;
        end else begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R5 unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(cyc == e.due, "R5 latency", cyc, e.due);
                    chk(out_smp == 16'(e.val), "R2 R4 output sample", out_smp, e.val);
                end
            end else begin
                chk(out_smp == prev_out, "R9 hold between strobes", out_smp, prev_out);
            end
            prev_out <= out_smp;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
        chk(out_smp == 16'sd0, "R1 reset output", out_smp, 0);
        chk(band_idx == 3'd0, "R1 reset index", band_idx, 0);

        // R6: bottom clamp, climb to top clamp, simultaneous pulses
        step(1'b0, 1'b1);
        for (int i = 0; i < 9; i++) step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1);

        // R2 R7: impulse response at index 4
        send(1000);
        for (int i = 0; i < 8; i++) send(0);

        // R3 R4: drive into both rails at index 0
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1);
        for (int i = 0; i < 24; i++) send(32767);
        for (int i = 0; i < 24; i++) send(-32768);
        chk(hit_pos && hit_neg, "R3 both state rails reached", {hit_pos, hit_neg}, 3);

        // R8: step pulse on the same edge as a strobe
        send(-20000, 1'b1, 1'b0);
        send(12345);
        send(-700, 1'b0, 1'b1);
        send(700);

        // Mixed pattern at index 7
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0);
        for (int i = 0; i < 12; i++) send((i % 2 == 0) ? 9000 - i * 300 : -8000 + i * 250);

        // R1: reset mid-run clears the states
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        sb.delete();
        m_s1 = 0;
        m_s2 = 0;
        m_idx = 0;
        chk(band_idx == 3'd0, "R1 index after reset", band_idx, 0);
        send(500);
        send(0);
        repeat (6) @(negedge clk);
        chk(sb.size() == 0, "R5 all outputs delivered", sb.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule